// File: doc/BRIEF.md
# Workspace Register Sequencer

This block is the linkage and register-addressing control for a processor that keeps its sixteen general registers in ordinary RAM. There is no register file. A workspace pointer (WP) holds the byte address of the active set of sixteen 16-bit words, so register n sits at WP + 2n. The sequencer turns register numbers into memory addresses and issues them on a single-word synchronous memory port. It also owns the program counter (PC), the WP and the status word (ST).

A decoded command arrives with its operands. The sequencer then runs every memory access that the command needs, one word at a time, and updates PC, WP and ST when the last access completes. There are two kinds of call. The context call fetches a new WP and a new PC from a two-word vector and parks the old WP, PC and ST in the top three registers of the new workspace. Swapping that one pointer replaces the whole register set. The light call only stores the return PC in a fixed link register of the current workspace. Each call has a matching return.

Top module: `wsp_seq`

## Requirements
- R1: After reset, PC is 0x0100, WP is 0x0080, ST is 0, and busy, mem_req and rd_valid are low.
- R2: Register n lives at byte address WP + 2n. Command code 1 (read register cmd_reg) makes one read there and returns the word on rd_data. Command code 2 (write register) stores cmd_data there with one write.
- R3: A memory request keeps mem_addr, mem_we and mem_wdata unchanged until mem_ready is seen high at a clock edge. Each such edge completes exactly one word access.
- R4: busy rises on the edge that accepts a memory-using command and falls on the edge that completes its last access. A command presented while busy is ignored and makes no access.
- R5: Command code 3 (context call, vector address in cmd_addr) performs these accesses in order: a read at V that gives the new WP, a read at V+2 that gives the new PC, then writes of the old WP, old PC and old ST to new-WP registers 13, 14 and 15 (offsets 0x1A, 0x1C, 0x1E).
- R6: When a context call ends, WP and PC hold the values read from the vector, and ST is unchanged.
- R7: Command code 5 (light call, target in cmd_addr) writes the current PC to register 11 (offset 0x16) of the current workspace, then sets PC to the target. WP is unchanged.
- R8: Command code 6 (light return) makes one read of register 11 and loads PC from it. WP and ST are unchanged.
- R9: Command code 4 (context return) reads registers 13, 14 and 15 of the current workspace in that order. It loads WP, PC and ST from them together on the edge of the last read, and none of them changes earlier.
- R10: Command code 7 loads WP from cmd_addr and ST from cmd_data in one cycle, makes no memory access and never raises busy.
- R11: rd_valid is a single-cycle pulse on the edge that completes a register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present; accepted when busy is low |
| cmd_op | input | 3 | Command code |
| cmd_reg | input | 4 | Register number for read/write commands |
| cmd_addr | input | 16 | Vector address, call target or new WP |
| cmd_data | input | 16 | Write data or new ST |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this edge |
| pc | output | 16 | Program counter |
| wp | output | 16 | Workspace pointer |
| st | output | 16 | Status word |
| rd_data | output | 16 | Last register read result |
| rd_valid | output | 1 | rd_data updated this cycle |

## Verification
The hardest case to reach is a context return that has to restore a status different from the one saved. Reaching it takes a workspace, a call, a vector and a patched register 15 lined up through the ports alone. The stimulus builds the vector through ordinary register writes with WP moved onto the vector area. It then makes a light call to plant a known PC, makes the context call, and rewrites register 15 in the new workspace before returning. The register-address sweep repeats across several workspace bases and several memory-ready stall patterns, so that held requests are exercised in every sequence.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_RDREG     = 3'd1,
    OP_WRREG     = 3'd2,
    OP_CALL_CTX  = 3'd3,
    OP_RET_CTX   = 3'd4,
    OP_CALL_LITE = 3'd5,
    OP_RET_LITE  = 3'd6,
    OP_SETCTX    = 3'd7
  } wsp_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_VEC_WP,
    S_VEC_PC,
    S_SAV_WP,
    S_SAV_PC,
    S_SAV_ST,
    S_LD_WP,
    S_LD_PC,
    S_LD_ST,
    S_LNK_WR,
    S_LNK_RD,
    S_REG_RD,
    S_REG_WR
  } wsp_state_e;

endpackage

// File: rtl/wsp_rst_sync.sv
module wsp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/wsp_addr.sv
module wsp_addr #(
  parameter int W  = 16,
  parameter int RW = 4
) (
  input  logic [W-1:0]  base,
  input  logic [RW-1:0] idx,
  output logic [W-1:0]  addr
);

  localparam int OFFW = RW + 1;

  logic [OFFW-1:0] byte_off;

  assign byte_off = {idx, 1'b0};
  assign addr     = base + W'(byte_off);

endmodule

// File: rtl/wsp_ctx.sv
module wsp_ctx #(
  parameter int            W      = 16,
  parameter logic [W-1:0]  RST_PC = '0,
  parameter logic [W-1:0]  RST_WP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_wp,
  input  logic         ld_pc,
  input  logic         ld_st,
  input  logic [W-1:0] nx_wp,
  input  logic [W-1:0] nx_pc,
  input  logic [W-1:0] nx_st,
  output logic [W-1:0] wp,
  output logic [W-1:0] pc,
  output logic [W-1:0] st
);

  logic [W-1:0] wp_n, pc_n, st_n;

  always_comb begin
    wp_n = ld_wp ? nx_wp : wp;
    pc_n = ld_pc ? nx_pc : pc;
    st_n = ld_st ? nx_st : st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= RST_WP;
      pc <= RST_PC;
      st <= '0;
    end else begin
      wp <= wp_n;
      pc <= pc_n;
      st <= st_n;
    end
  end

endmodule

// File: rtl/wsp_fsm.sv
module wsp_fsm
  import wsp_pkg::*;
#(
  parameter int W         = 16,
  parameter int RW        = 4,
  parameter int LINK_REG  = 11,
  parameter int SAVE_BASE = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [RW-1:0] cmd_reg,
  input  logic [W-1:0]  cmd_addr,
  input  logic [W-1:0]  cmd_data,
  input  logic [W-1:0]  wp_i,
  input  logic [W-1:0]  pc_i,
  input  logic [W-1:0]  st_i,
  input  logic          mem_ready,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_wdata,
  output logic [W-1:0]  ag_base,
  output logic [RW-1:0] ag_idx,
  output logic          ld_wp,
  output logic          ld_pc,
  output logic          ld_st,
  output logic [W-1:0]  nx_wp,
  output logic [W-1:0]  nx_pc,
  output logic [W-1:0]  nx_st,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid
);

  localparam logic [RW-1:0] IDX_SWP = RW'(SAVE_BASE);
  localparam logic [RW-1:0] IDX_SPC = RW'(SAVE_BASE + 1);
  localparam logic [RW-1:0] IDX_SST = RW'(SAVE_BASE + 2);
  localparam logic [RW-1:0] IDX_LNK = RW'(LINK_REG);
  localparam logic [RW-1:0] IDX_V0  = RW'(0);
  localparam logic [RW-1:0] IDX_V1  = RW'(1);

  wsp_state_e   state, state_n;
  wsp_op_e      op;
  logic         accept, xfer;
  logic [W-1:0] vec_q, twp_q, tpc_q, dat_q;
  logic [RW-1:0] reg_q;
  logic         twp_en, tpc_en, rd_en;
  logic [W-1:0] tpc_n;

  assign op     = wsp_op_e'(cmd_op);
  assign accept = cmd_valid && (state == S_IDLE);
  assign xfer   = mem_req && mem_ready;
  assign busy   = (state != S_IDLE);

  // next state and memory request
  always_comb begin
    state_n   = state;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    ag_base   = wp_i;
    ag_idx    = IDX_V0;
    case (state)
      S_IDLE: begin
        if (accept) begin
          case (op)
            OP_RDREG:     state_n = S_REG_RD;
            OP_WRREG:     state_n = S_REG_WR;
            OP_CALL_CTX:  state_n = S_VEC_WP;
            OP_RET_CTX:   state_n = S_LD_WP;
            OP_CALL_LITE: state_n = S_LNK_WR;
            OP_RET_LITE:  state_n = S_LNK_RD;
            default:      state_n = S_IDLE;
          endcase
        end
      end
      S_VEC_WP: begin
        mem_req = 1'b1; ag_base = vec_q; ag_idx = IDX_V0;
        if (mem_ready) state_n = S_VEC_PC;
      end
      S_VEC_PC: begin
        mem_req = 1'b1; ag_base = vec_q; ag_idx = IDX_V1;
        if (mem_ready) state_n = S_SAV_WP;
      end
      S_SAV_WP: begin
        mem_req = 1'b1; mem_we = 1'b1; ag_base = twp_q; ag_idx = IDX_SWP;
        mem_wdata = wp_i;
        if (mem_ready) state_n = S_SAV_PC;
      end
      S_SAV_PC: begin
        mem_req = 1'b1; mem_we = 1'b1; ag_base = twp_q; ag_idx = IDX_SPC;
        mem_wdata = pc_i;
        if (mem_ready) state_n = S_SAV_ST;
      end
      S_SAV_ST: begin
        mem_req = 1'b1; mem_we = 1'b1; ag_base = twp_q; ag_idx = IDX_SST;
        mem_wdata = st_i;
        if (mem_ready) state_n = S_IDLE;
      end
      S_LD_WP: begin
        mem_req = 1'b1; ag_idx = IDX_SWP;
        if (mem_ready) state_n = S_LD_PC;
      end
      S_LD_PC: begin
        mem_req = 1'b1; ag_idx = IDX_SPC;
        if (mem_ready) state_n = S_LD_ST;
      end
      S_LD_ST: begin
        mem_req = 1'b1; ag_idx = IDX_SST;
        if (mem_ready) state_n = S_IDLE;
      end
      S_LNK_WR: begin
        mem_req = 1'b1; mem_we = 1'b1; ag_idx = IDX_LNK; mem_wdata = pc_i;
        if (mem_ready) state_n = S_IDLE;
      end
      S_LNK_RD: begin
        mem_req = 1'b1; ag_idx = IDX_LNK;
        if (mem_ready) state_n = S_IDLE;
      end
      S_REG_RD: begin
        mem_req = 1'b1; ag_idx = reg_q;
        if (mem_ready) state_n = S_IDLE;
      end
      S_REG_WR: begin
        mem_req = 1'b1; mem_we = 1'b1; ag_idx = reg_q; mem_wdata = dat_q;
        if (mem_ready) state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  // context register loads
  always_comb begin
    ld_wp = 1'b0;
    ld_pc = 1'b0;
    ld_st = 1'b0;
    nx_wp = twp_q;
    nx_pc = tpc_q;
    nx_st = mem_rdata;
    if (accept && (op == OP_SETCTX)) begin
      ld_wp = 1'b1; nx_wp = cmd_addr;
      ld_st = 1'b1; nx_st = cmd_data;
    end
    if (xfer) begin
      case (state)
        S_SAV_ST: begin ld_wp = 1'b1; ld_pc = 1'b1; end
        S_LD_ST:  begin ld_wp = 1'b1; ld_pc = 1'b1; ld_st = 1'b1; end
        S_LNK_WR: ld_pc = 1'b1;
        S_LNK_RD: begin ld_pc = 1'b1; nx_pc = mem_rdata; end
        default: ;
      endcase
    end
  end

  // temporaries: enables
  assign twp_en = xfer && ((state == S_VEC_WP) || (state == S_LD_WP));
  assign tpc_en = accept || (xfer && ((state == S_VEC_PC) || (state == S_LD_PC)));
  assign tpc_n  = accept ? cmd_addr : mem_rdata;
  assign rd_en  = xfer && (state == S_REG_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      reg_q <= '0;
      dat_q <= '0;
    end else if (accept) begin
      vec_q <= cmd_addr;
      reg_q <= cmd_reg;
      dat_q <= cmd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      twp_q <= '0;
    else if (twp_en) twp_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tpc_q <= '0;
    else if (tpc_en) tpc_q <= tpc_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

endmodule

// File: rtl/wsp_seq.sv
module wsp_seq
  import wsp_pkg::*;
#(
  parameter int           W        = 16,
  parameter int           NREG     = 16,
  parameter int           LINK_REG = 11,
  parameter logic [W-1:0] RST_PC   = W'(16'h0100),
  parameter logic [W-1:0] RST_WP   = W'(16'h0080),
  localparam int          RW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [RW-1:0] cmd_reg,
  input  logic [W-1:0]  cmd_addr,
  input  logic [W-1:0]  cmd_data,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  input  logic          mem_ready,
  output logic [W-1:0]  pc,
  output logic [W-1:0]  wp,
  output logic [W-1:0]  st,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid
);

  localparam int SAVE_BASE = NREG - 3;

  logic          rst_n_s;
  logic [W-1:0]  ag_base;
  logic [RW-1:0] ag_idx;
  logic          ld_wp, ld_pc, ld_st;
  logic [W-1:0]  nx_wp, nx_pc, nx_st;

  wsp_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  wsp_fsm #(
    .W         (W),
    .RW        (RW),
    .LINK_REG  (LINK_REG),
    .SAVE_BASE (SAVE_BASE)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_reg   (cmd_reg),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .wp_i      (wp),
    .pc_i      (pc),
    .st_i      (st),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .ag_base   (ag_base),
    .ag_idx    (ag_idx),
    .ld_wp     (ld_wp),
    .ld_pc     (ld_pc),
    .ld_st     (ld_st),
    .nx_wp     (nx_wp),
    .nx_pc     (nx_pc),
    .nx_st     (nx_st),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  wsp_addr #(.W(W), .RW(RW)) u_addr (
    .base (ag_base),
    .idx  (ag_idx),
    .addr (mem_addr)
  );

  wsp_ctx #(.W(W), .RST_PC(RST_PC), .RST_WP(RST_WP)) u_ctx (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ld_wp (ld_wp),
    .ld_pc (ld_pc),
    .ld_st (ld_st),
    .nx_wp (nx_wp),
    .nx_pc (nx_pc),
    .nx_st (nx_st),
    .wp    (wp),
    .pc    (pc),
    .st    (st)
  );

endmodule

// File: rtl/wsp_seq_chk.sv
module wsp_seq_chk
  import wsp_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic         busy,
  input logic         mem_req,
  input logic         mem_we,
  input logic         mem_ready,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic [W-1:0] wp,
  input logic [W-1:0] pc,
  input logic         rd_valid
);

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata))); // R3

  AST_CTX_STABLE_MID: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(wp) && $stable(pc)))); // R9

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R11

  AST_SETCTX_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (cmd_op == OP_SETCTX)) |=> (!busy && !mem_req)); // R10

endmodule

bind wsp_seq wsp_seq_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .wp        (wp),
  .pc        (pc),
  .rd_valid  (rd_valid)
);

// File: tb/wsp_seq_test.sv
module wsp_seq_test;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [3:0]  cmd_reg;
  logic [15:0] cmd_addr, cmd_data;
  logic        busy, mem_req, mem_we, mem_ready, rd_valid;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pc, wp, st, rd_data;

  wsp_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .pc(pc), .wp(wp), .st(st),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int midchg = 0;
  int hold_err = 0;
  int rdy_mode = 0;
  int nlog = 0;

  logic [15:0] mem [0:1023];
  logic [15:0] log_addr [0:1023];
  logic [15:0] log_data [0:1023];
  logic        log_we   [0:1023];
  logic [7:0]  lfsr = 8'hA5;
  int          rcnt = 0;
  logic        pend = 1'b0;
  logic [15:0] p_addr = '0;
  logic        p_we = 1'b0;

  assign mem_rdata = mem[mem_addr[10:1]];

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  end

  // memory model: ready decided and transfer logged at the falling edge
  always @(negedge clk) begin
    logic r;
    case (rdy_mode)
      0:       r = 1'b1;
      1:       r = (rcnt % 3) == 2;
      default: r = lfsr[0];
    endcase
    rcnt <= rcnt + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= r;
    if (rst_n && pend && (!mem_req || mem_addr != p_addr || mem_we != p_we)) hold_err <= hold_err + 1;
    pend   <= mem_req && !r;
    p_addr <= mem_addr;
    p_we   <= mem_we;
    if (mem_req && r && nlog < 1024) begin
      log_addr[nlog] <= mem_addr;
      log_we[nlog]   <= mem_we;
      log_data[nlog] <= mem_wdata;
      nlog <= nlog + 1;
      if (mem_we) mem[mem_addr[10:1]] <= mem_wdata;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R4 watchdog expired actual busy=%0b expected idle", busy);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_log(input string tag, input int i, input logic [15:0] a,
                         input logic we, input logic [15:0] d);
    chk(tag, log_addr[i], a);
    chk(tag, 16'(log_we[i]), 16'(we));
    if (we) chk(tag, log_data[i], d);
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [15:0] a,
                         input logic [15:0] d, input logic [3:0] r);
    logic [15:0] p_wp, p_pc, p_st;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_reg = r;
    p_wp = wp; p_pc = pc; p_st = st;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) begin
      if (wp !== p_wp || pc !== p_pc || st !== p_st) midchg++;
      @(negedge clk);
    end
  endtask

  initial begin
    int base;
    logic [15:0] wpv, val, wpa, sta, tgt, vec, nwp, npc, oldpc;
    cmd_valid = 1'b0; cmd_op = '0; cmd_reg = '0; cmd_addr = '0; cmd_data = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pc", pc, 16'h0100);
    chk("R1 wp", wp, 16'h0080);
    chk("R1 st", st, 16'h0000);
    chk("R1 busy/req/rdv", {13'b0, busy, mem_req, rd_valid}, 16'h0000);

    // R2 sweep over workspaces, all registers, several stall patterns
    for (int w = 0; w < 3; w++) begin
      wpv = (w == 0) ? 16'h0080 : (w == 1) ? 16'h0200 : 16'h05E0;
      rdy_mode = w;
      base = nlog;
      run_cmd(3'd7, wpv, wpv ^ 16'h5A5A, 4'd0);
      chk("R10 wp", wp, wpv);
      chk("R10 st", st, wpv ^ 16'h5A5A);
      chk("R10 no access", 16'(nlog - base), 16'd0);
      for (int n = 0; n < 16; n++) begin
        val = 16'(wpv * 3 + n * 257);
        base = nlog;
        run_cmd(3'd2, 16'h0, val, 4'(n));
        chk("R3 one access", 16'(nlog - base), 16'd1);
        chk_log("R2 write", base, wpv + 16'(2 * n), 1'b1, val);
      end
      for (int n = 0; n < 16; n++) begin
        val = 16'(wpv * 3 + n * 257);
        base = nlog;
        run_cmd(3'd1, 16'h0, 16'h0, 4'(n));
        chk("R2 read data", rd_data, val);
        chk_log("R2 read addr", base, wpv + 16'(2 * n), 1'b0, 16'h0);
        chk("R11 rd_valid high", 16'(rd_valid), 16'd1);
        @(negedge clk);
        chk("R11 rd_valid pulse", 16'(rd_valid), 16'd0);
      end
    end

    // calls and returns
    for (int k = 0; k < 4; k++) begin
      rdy_mode = k % 3;
      wpa = 16'h0100 + 16'(k * 64);
      sta = 16'h1000 + 16'(k);
      tgt = 16'h0300 + 16'(k);
      vec = 16'h0400 + 16'(k * 4);
      nwp = 16'h0600 + 16'(k * 32);
      npc = 16'h0700 + 16'(k * 16);
      // build vector with register writes
      run_cmd(3'd7, vec, 16'h0, 4'd0);
      run_cmd(3'd2, 16'h0, nwp, 4'd0);
      run_cmd(3'd2, 16'h0, npc, 4'd1);
      run_cmd(3'd7, wpa, sta, 4'd0);
      oldpc = pc;
      base = nlog;
      run_cmd(3'd5, tgt, 16'h0, 4'd0);
      chk_log("R7 link write", base, wpa + 16'h0016, 1'b1, oldpc);
      chk("R7 pc", pc, tgt);
      chk("R7 wp", wp, wpa);
      base = nlog;
      run_cmd(3'd6, 16'h0, 16'h0, 4'd0);
      chk_log("R8 link read", base, wpa + 16'h0016, 1'b0, 16'h0);
      chk("R8 pc", pc, oldpc);
      chk("R8 wp/st", wp ^ st, wpa ^ sta);
      run_cmd(3'd5, tgt, 16'h0, 4'd0);
      base = nlog;
      run_cmd(3'd3, vec, 16'h0, 4'd0);
      chk("R5 count", 16'(nlog - base), 16'd5);
      chk_log("R5 vec wp", base,     vec,                  1'b0, 16'h0);
      chk_log("R5 vec pc", base + 1, vec + 16'h0002,       1'b0, 16'h0);
      chk_log("R5 save wp", base + 2, nwp + 16'h001A,      1'b1, wpa);
      chk_log("R5 save pc", base + 3, nwp + 16'h001C,      1'b1, tgt);
      chk_log("R5 save st", base + 4, nwp + 16'h001E,      1'b1, sta);
      chk("R6 wp", wp, nwp);
      chk("R6 pc", pc, npc);
      chk("R6 st", st, sta);
      run_cmd(3'd2, 16'h0, 16'h4000 + 16'(k), 4'd15);
      base = nlog;
      run_cmd(3'd4, 16'h0, 16'h0, 4'd0);
      chk("R9 count", 16'(nlog - base), 16'd3);
      chk_log("R9 rd13", base,     nwp + 16'h001A, 1'b0, 16'h0);
      chk_log("R9 rd14", base + 1, nwp + 16'h001C, 1'b0, 16'h0);
      chk_log("R9 rd15", base + 2, nwp + 16'h001E, 1'b0, 16'h0);
      chk("R9 wp", wp, wpa);
      chk("R9 pc", pc, tgt);
      chk("R9 st", st, 16'h4000 + 16'(k));
    end

    // R4: command presented while busy is ignored
    rdy_mode = 1;
    oldpc = pc;
    base = nlog;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_reg = 4'd3;
    @(negedge clk);
    chk("R4 busy after accept", 16'(busy), 16'd1);
    cmd_op = 3'd5; cmd_addr = 16'h0777;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R4 ignored pc", pc, oldpc);
    chk("R4 ignored access", 16'(nlog - base), 16'd1);

    chk("R9 no mid-command change", 16'(midchg), 16'd0);
    chk("R3 request held", 16'(hold_err), 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule